// File: doc/BRIEF.md
# Width-Adaptive Local Bus Cycle Sequencer

This block runs one local-bus access at a time. An access can be a single beat or a burst. It accepts a request through a valid/ready handshake while idle. It then steps through one address state, then data states (with wait states wherever the target is not ready), then one recovery state, and returns to idle. Along the way it drives four active-low byte-lane enables, an active-low data strobe, a transmit/receive direction line and a data/code indicator.

Each request carries a region width code, and the code changes what the four enable pins mean. On a 32-bit region each pin selects a byte lane. On a 16-bit region two pins are high/low byte enables and one pin carries address bit 1. On an 8-bit region two pins carry address bits 1 and 0. Whenever pins carry address bits, those bits step forward by one beat on every ready sampled during the access. The surrounding controller supplies the low two address bits, the beat count and the lane mask. Splitting misaligned transfers is the controller's job, not this block's.

Top module: `lbus_seq`

## Requirements
- R1: After reset, req_ready_o=1, be_no=4'hF, den_no=1, dtr_o=0 and dc_o=0. req_ready_o is high only in idle, and a request is taken on a clock edge where req_valid_i and req_ready_o are both high.
- R2: The cycle after acceptance is the address state. In it, den_no=1, req_ready_o=0 and be_no already holds its access value. rdy_i is ignored in this state.
- R3: den_no is low from the cycle after the address state through the cycle in which the last ready is sampled. It is high in every other cycle.
- R4: In a data state where rdy_i is low, the access waits. The beat count and the address bits do not advance, and be_no does not change.
- R5: After the last ready, exactly one recovery cycle follows, with den_no=1, be_no=4'hF and req_ready_o=0. A request held valid during recovery is taken only in the following idle cycle.
- R6: For width code 2'b10 (32-bit), and for 2'b11 (treated as 32-bit), be_no[i] = ~req_lanes_i[i]. Bit 3 selects data bits 31:24 and bit 0 selects bits 7:0. The value does not change across the beats of a burst.
- R7: For width code 2'b01 (16-bit): be_no[3] = ~req_lanes_i[1] (high byte), be_no[0] = ~req_lanes_i[0] (low byte), be_no[2] = 1, and be_no[1] = address bit 1.
- R8: For width code 2'b00 (8-bit): be_no[3] = be_no[2] = 1, be_no[1] = address bit 1 and be_no[0] = address bit 0.
- R9: The address bits start at req_addr_lo_i. Each sampled ready adds 1 on an 8-bit region and 2 on a 16-bit region, wrapping modulo 4. The new value shows in the next data state.
- R10: dtr_o equals the request's write flag from the address state onward, and keeps that value in idle until the next address state. It never changes while den_no is low.
- R11: dc_o equals the request's data flag (1 = data, 0 = instruction), with the same timing as dtr_o.
- R12: A beat count of 0 is treated as one beat. Otherwise req_beats_i beats are transferred.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request accepted when high with valid (idle) |
| req_addr_lo_i | input | 2 | Low two bits of the start address |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_data_i | input | 1 | 1 = data access, 0 = instruction fetch |
| req_beats_i | input | BEAT_W | Beat count (0 treated as 1) |
| req_lanes_i | input | 4 | Active-high byte lane mask, bit 0 = bits 7:0 |
| width_i | input | 2 | Region width: 00 8-bit, 01 16-bit, 1x 32-bit |
| rdy_i | input | 1 | Target ready, sampled in data states |
| be_no | output | 4 | Byte enables / low address bits, active low |
| den_no | output | 1 | Data strobe, low in data states |
| dtr_o | output | 1 | Direction: 1 transmit, 0 receive |
| dc_o | output | 1 | 1 = data access, 0 = instruction access |

## Verification
Two events can fall in the same cycle: the final ready of an access, which also advances the address bits and starts recovery, and a new request that is already valid. The bench holds req_valid_i high from acceptance through the end of the access. In the recovery cycle it checks that req_ready_o is low and that the enables are all high, not showing the advanced address. It then checks that the held request is taken in the idle cycle and that its own direction value appears in the next address state.

// File: rtl/lbus_seq_pkg.sv
package lbus_seq_pkg;
  typedef enum logic [1:0] {
    BW_8   = 2'b00,
    BW_16  = 2'b01,
    BW_32  = 2'b10,
    BW_32X = 2'b11
  } bus_w_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ADDR,
    ST_DATA,
    ST_RECV
  } phase_e;

  localparam int unsigned LANE_N = 4;
endpackage

// File: rtl/lbus_seq_ctl.sv
module lbus_seq_ctl
  import lbus_seq_pkg::*;
#(
  parameter int unsigned BEAT_W = 4
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      req_valid_i,
  input  logic [1:0]                req_addr_lo_i,
  input  logic                      req_write_i,
  input  logic                      req_data_i,
  input  logic [BEAT_W-1:0]         req_beats_i,
  input  logic [LANE_N-1:0]         req_lanes_i,
  input  logic [1:0]                width_i,
  input  logic                      rdy_i,
  output logic                      req_ready_o,
  output phase_e                    phase_o,
  output bus_w_e                    width_o,
  output logic [LANE_N-1:0]         lanes_o,
  output logic [1:0]                addr_lo_o,
  output logic                      dtr_o,
  output logic                      dc_o
);
  phase_e              phase_q;
  bus_w_e              width_q;
  logic [LANE_N-1:0]   lanes_q;
  logic [1:0]          addr_q;
  logic [BEAT_W-1:0]   left_q;
  logic                dtr_q, dc_q;
  logic [1:0]          step;

  always_comb begin
    case (width_q)
      BW_8:    step = 2'd1;
      BW_16:   step = 2'd2;
      default: step = 2'd0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= ST_IDLE;
      width_q <= BW_32;
      lanes_q <= '0;
      addr_q  <= '0;
      left_q  <= '0;
      dtr_q   <= 1'b0;
      dc_q    <= 1'b0;
    end else begin
      case (phase_q)
        ST_IDLE: if (req_valid_i) begin
          phase_q <= ST_ADDR;
          width_q <= bus_w_e'(width_i);
          lanes_q <= req_lanes_i;
          addr_q  <= req_addr_lo_i;
          left_q  <= (req_beats_i == '0) ? BEAT_W'(1) : req_beats_i;
          dtr_q   <= req_write_i;
          dc_q    <= req_data_i;
        end
        ST_ADDR: phase_q <= ST_DATA;
        ST_DATA: if (rdy_i) begin
          addr_q <= addr_q + step;
          if (left_q == BEAT_W'(1)) phase_q <= ST_RECV;
          else                      left_q  <= left_q - BEAT_W'(1);
        end
        default: phase_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o = (phase_q == ST_IDLE);
  assign phase_o     = phase_q;
  assign width_o     = width_q;
  assign lanes_o     = lanes_q;
  assign addr_lo_o   = addr_q;
  assign dtr_o       = dtr_q;
  assign dc_o        = dc_q;

  // wait state freezes beat count and address bits
  assert_wait_holds_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == ST_DATA && !rdy_i) |=> ($stable(addr_q) && $stable(left_q) && phase_q == ST_DATA));

  assert_byte_step_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == ST_DATA && rdy_i && width_q == BW_8 && left_q != BEAT_W'(1))
    |=> (addr_q == $past(addr_q) + 2'd1));

  assert_recv_one_cycle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == ST_RECV) |=> (phase_q == ST_IDLE));
endmodule

// File: rtl/lbus_seq_lanes.sv
module lbus_seq_lanes
  import lbus_seq_pkg::*;
(
  input  phase_e              phase_i,
  input  bus_w_e              width_i,
  input  logic [LANE_N-1:0]   lanes_i,
  input  logic [1:0]          addr_lo_i,
  output logic [LANE_N-1:0]   be_no
);
  logic [LANE_N-1:0] be_w32;

  for (genvar g = 0; g < LANE_N; g++) begin : g_lane
    assign be_w32[g] = ~lanes_i[g];
  end

  always_comb begin
    if (phase_i == ST_ADDR || phase_i == ST_DATA) begin
      case (width_i)
        BW_8:    be_no = {2'b11, addr_lo_i};
        BW_16:   be_no = {~lanes_i[1], 1'b1, addr_lo_i[1], ~lanes_i[0]};
        default: be_no = be_w32;
      endcase
    end else begin
      be_no = '1;
    end
  end
endmodule

// File: rtl/lbus_seq.sv
module lbus_seq
  import lbus_seq_pkg::*;
#(
  parameter int unsigned BEAT_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [1:0]        req_addr_lo_i,
  input  logic              req_write_i,
  input  logic              req_data_i,
  input  logic [BEAT_W-1:0] req_beats_i,
  input  logic [3:0]        req_lanes_i,
  input  logic [1:0]        width_i,
  input  logic              rdy_i,
  output logic [3:0]        be_no,
  output logic              den_no,
  output logic              dtr_o,
  output logic              dc_o
);
  phase_e            phase;
  bus_w_e            width_q;
  logic [LANE_N-1:0] lanes_q;
  logic [1:0]        addr_lo;

  lbus_seq_ctl #(.BEAT_W(BEAT_W)) u_ctl (
    .clk_i, .rst_ni, .req_valid_i, .req_addr_lo_i, .req_write_i, .req_data_i,
    .req_beats_i, .req_lanes_i, .width_i, .rdy_i, .req_ready_o,
    .phase_o(phase), .width_o(width_q), .lanes_o(lanes_q), .addr_lo_o(addr_lo),
    .dtr_o, .dc_o
  );

  lbus_seq_lanes u_lanes (
    .phase_i(phase), .width_i(width_q), .lanes_i(lanes_q),
    .addr_lo_i(addr_lo), .be_no
  );

  assign den_no = (phase != ST_DATA);

  assert_take_to_addr_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> (den_no && !req_ready_o));

  assert_den_after_addr_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(den_no) |-> $past(!req_ready_o));

  assert_recv_idle_lanes_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(den_no) |-> (be_no == 4'hF && !req_ready_o));

  assert_dir_steady_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!den_no && $past(!den_no)) |-> ($stable(dtr_o) && $stable(dc_o)));

  assert_idle_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (den_no && be_no == 4'hF));
endmodule

// File: tb/lbus_seq_tb.sv
module lbus_seq_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       valid = 1'b0, ready;
  logic [1:0] addr_lo = '0;
  logic       wr = 1'b0, dflag = 1'b0;
  logic [3:0] beats = '0, lanes = '0;
  logic [1:0] width = '0;
  logic       rdy = 1'b0;
  logic [3:0] be_n;
  logic       den_n, dtr, dc;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  lbus_seq u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(valid), .req_ready_o(ready),
    .req_addr_lo_i(addr_lo), .req_write_i(wr), .req_data_i(dflag),
    .req_beats_i(beats), .req_lanes_i(lanes), .width_i(width), .rdy_i(rdy),
    .be_no(be_n), .den_no(den_n), .dtr_o(dtr), .dc_o(dc)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [3:0] exp_be(input logic [1:0] w, input logic [3:0] l, input logic [1:0] a);
    case (w)
      2'b00:   return {2'b11, a};
      2'b01:   return {~l[1], 1'b1, a[1], ~l[0]};
      default: return ~l;
    endcase
  endfunction

  task automatic run_access(input logic [1:0] w, input logic [3:0] l, input logic [1:0] a,
                            input int n, input logic wrf, input logic dcf, input int waits,
                            input string tag);
    logic [1:0] cur = a;
    int nb = (n == 0) ? 1 : n;
    @(negedge clk);
    chk(ready, 1, {tag, " R1 idle ready"});
    valid = 1'b1; width = w; lanes = l; addr_lo = a; beats = 4'(n); wr = wrf; dflag = dcf;
    @(negedge clk);
    valid = 1'b0;
    chk(ready, 0, {tag, " R2 busy"});
    chk(den_n, 1, {tag, " R2 den high in addr"});
    chk(be_n, exp_be(w, l, cur), {tag, " R2 be in addr"});
    chk(dtr, wrf, {tag, " R10 dtr"});
    chk(dc, dcf, {tag, " R11 dc"});
    rdy = 1'b1;  // must be ignored in address state
    @(negedge clk);
    for (int b = 0; b < nb; b++) begin
      for (int k = 0; k < waits; k++) begin
        chk(den_n, 0, {tag, " R3 den low in wait"});
        chk(be_n, exp_be(w, l, cur), {tag, " R4 be held in wait"});
        rdy = 1'b0;
        @(negedge clk);
      end
      chk(den_n, 0, {tag, " R3 den low"});
      chk(be_n, exp_be(w, l, cur), {tag, " R6/R7/R8/R9 be beat"});
      chk(dtr, wrf, {tag, " R10 dtr steady"});
      chk(dc, dcf, {tag, " R11 dc steady"});
      rdy = 1'b1;
      @(negedge clk);
      if (w == 2'b00) cur = cur + 2'd1;
      else if (w == 2'b01) cur = cur + 2'd2;
    end
    rdy = 1'b0;
    chk(den_n, 1, {tag, " R5 recovery den"});
    chk(be_n, 4'hF, {tag, " R5 recovery be"});
    chk(ready, 0, {tag, " R5 recovery not ready"});
    @(negedge clk);
    chk(ready, 1, {tag, " R5 idle after recovery"});
    chk(be_n, 4'hF, {tag, " R1 idle be"});
    chk(dtr, wrf, {tag, " R10 dtr held idle"});
    chk(dc, dcf, {tag, " R11 dc held idle"});
  endtask

  task automatic t_reset;
    chk(ready, 1, "R1 reset ready");
    chk(be_n, 4'hF, "R1 reset be");
    chk(den_n, 1, "R1 reset den");
    chk(dtr, 0, "R1 reset dtr");
    chk(dc, 0, "R1 reset dc");
  endtask

  task automatic t_overlap;
    @(negedge clk);
    valid = 1'b1; width = 2'b10; lanes = 4'hF; addr_lo = 2'd0; beats = 4'd1; wr = 1'b1; dflag = 1'b1;
    @(negedge clk);
    wr = 1'b0; dflag = 1'b0;     // next request held valid
    chk(ready, 0, "R2 overlap addr busy");
    @(negedge clk);
    chk(den_n, 0, "R3 overlap data");
    rdy = 1'b1;
    @(negedge clk);
    rdy = 1'b0;
    chk(ready, 0, "R5 overlap no take in recovery");
    chk(be_n, 4'hF, "R5 overlap recovery be");
    chk(dtr, 1, "R10 overlap dtr kept");
    @(negedge clk);
    chk(ready, 1, "R1 overlap taken in idle");
    @(negedge clk);
    valid = 1'b0;
    chk(den_n, 1, "R2 overlap second addr");
    chk(dtr, 0, "R10 overlap second dtr");
    chk(dc, 0, "R11 overlap second dc");
    @(negedge clk);
    rdy = 1'b1;
    @(negedge clk);
    rdy = 1'b0;
    @(negedge clk);
    chk(ready, 1, "R5 overlap done");
  endtask

  initial begin
    #(4 * 20000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    run_access(2'b10, 4'hF, 2'd0, 4, 1'b0, 1'b1, 1, "R6 w32 read burst");
    run_access(2'b11, 4'b0101, 2'd0, 2, 1'b1, 1'b1, 0, "R6 w32x write");
    run_access(2'b01, 4'b0011, 2'd2, 3, 1'b0, 1'b1, 2, "R7 R9 w16 read");
    run_access(2'b01, 4'b0010, 2'd0, 1, 1'b1, 1'b1, 0, "R7 w16 high byte");
    run_access(2'b00, 4'h0, 2'd3, 5, 1'b1, 1'b1, 1, "R8 R9 w8 write wrap");
    run_access(2'b00, 4'h0, 2'd1, 0, 1'b0, 1'b0, 0, "R12 R11 zero beats fetch");
    t_overlap();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule